// File: doc/BRIEF.md
# SSB Decode Control Sequencer

This block is the control core for decoding one synchronization signal block. It writes the incoming sample stream into an external grid memory, waits for a start strobe that says the grid is complete, and then walks the decode through its stages. Three stages belong to the physical channel: grid capture, reference-signal search and symbol demodulation. Three outcomes belong to the transport channel: rate recovery, polar decoding and a CRC verdict. Each datapath stage sits outside the block. The sequencer sends it a one-cycle start pulse and waits for its one-cycle done pulse, so any stage can be swapped for a model.

Progress shows on two independent status codes, one per channel layer. When demodulation hands off to the transport stage, the grid is free, and a ready-for-next pulse lets the producer start writing the next block's samples while the transport stage is still running. A result pulse qualifies the block index and the 32-bit payload together. The block index is derived from the search result and the burst size captured at start.

Top module: `ssbDecodeSeq`

## Requirements
- R1: A high `rst` at a clock edge returns `phyStatus` and `trpStatus` to 0. It clears every start, result and ready pulse, the grid address, the captured configuration, `blockIdx` and `payload`, and it abandons any decode in progress.
- R2: While `phyStatus` is 0 or 1, `gridWrEn` follows `sampleValid` in the same cycle. Each write moves `gridWrAddr` up by one, wrapping from GRID_DEPTH-1 to 0. A write while `phyStatus` is 0 moves it to 1 (grid capture) on the next cycle.
- R3: A start is accepted when `phyStatus` is 0 or 1 and `trpStatus` is not 1 or 2. On the next cycle `phyStatus` is 2, `trpStatus` is 0, `searchStart` pulses for one cycle, `gridWrAddr` is 0, and `cfgCellId` / `cfgBurstCode` hold the values present on the start cycle until the next accepted start.
- R4: A start that arrives while `phyStatus` is 2 or 3, or while `trpStatus` is 1 or 2, has no effect.
- R5: `searchDone` while `phyStatus` is 2 captures `searchIbar`. On the next cycle `phyStatus` is 3 and `demodStart` pulses.
- R6: `demodDone` while `phyStatus` is 3 gives, on the next cycle, `phyStatus` 0, `trpStatus` 1, and one-cycle pulses on `rateStart` and `nextReady`.
- R7: `rateDone` while `trpStatus` is 1 gives, on the next cycle, `trpStatus` 2 and a `polarStart` pulse.
- R8: `polarDone` while `trpStatus` is 2 gives, on the next cycle, `trpStatus` 4 if `polarCrcOk` was 1 or 3 if it was 0. In that same cycle one `resultValid` pulse qualifies `blockIdx` and `payload`, and `payload` equals `polarPayload` from the done cycle.
- R9: `blockIdx` is `{0, ibar[1:0]}` when the captured burst code is 0 (four blocks per burst). For any other code, including 1 (eight blocks per burst), it is `ibar[2:0]`.
- R10: The verdict codes 3 and 4 hold until an accepted start or a reset.
- R11: A done pulse from a stage that is not active, or a sample while `phyStatus` is 2 or 3, changes no output: the status codes, the address and the pulses stay as they were, and `gridWrEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Grid-complete start strobe; qualifies cellIdIn and burstCodeIn |
| cellIdIn | input | 10 | Cell identifier |
| burstCodeIn | input | 2 | Burst size code (0 = four, 1 = eight) |
| sampleValid | input | 1 | Sample qualifier |
| sampleRe | input | 16 | Sample real part |
| sampleIm | input | 16 | Sample imaginary part |
| gridWrEn | output | 1 | Grid memory write enable |
| gridWrAddr | output | 10 | Grid memory write address |
| gridWrRe | output | 16 | Grid write data, real part |
| gridWrIm | output | 16 | Grid write data, imaginary part |
| cfgCellId | output | 10 | Captured cell identifier for the stages |
| cfgBurstCode | output | 2 | Captured burst code for the stages |
| searchStart | output | 1 | Reference-signal search start pulse |
| searchDone | input | 1 | Search done pulse |
| searchIbar | input | 3 | Search result, valid with searchDone |
| demodStart | output | 1 | Symbol demodulation start pulse |
| demodDone | input | 1 | Demodulation done pulse |
| rateStart | output | 1 | Rate recovery start pulse |
| rateDone | input | 1 | Rate recovery done pulse |
| polarStart | output | 1 | Polar decode start pulse |
| polarDone | input | 1 | Polar decode done pulse |
| polarCrcOk | input | 1 | CRC verdict, valid with polarDone |
| polarPayload | input | 32 | Decoded payload, valid with polarDone |
| phyStatus | output | 2 | Physical-channel progress code |
| trpStatus | output | 3 | Transport-channel progress code |
| blockIdx | output | 3 | Block index, valid with resultValid |
| payload | output | 32 | Decoded payload, valid with resultValid |
| resultValid | output | 1 | Result pulse |
| nextReady | output | 1 | Next-block grid may be written |

## Verification
The bench runs the sequencer through a CRC-pass decode with burst code 0 and search result 7. This separates the masked index 3 from the raw value. A second, CRC-fail decode uses burst code 1 and search result 5, and it writes samples while the transport stage is still busy, which shows that the two status registers move independently. Stray done pulses, samples and starts are injected into every stage where they should be ignored. A mid-decode reset and a write run long enough to wrap the grid address cover the remaining boundaries. A behavioural model predicts every output on every cycle.

// File: rtl/ssbSeqPkg.sv
package ssbSeqPkg;

  typedef enum logic [1:0] {
    PHY_IDLE   = 2'd0,
    PHY_GRID   = 2'd1,
    PHY_SEARCH = 2'd2,
    PHY_DEMOD  = 2'd3
  } phyState_t;

  typedef enum logic [2:0] {
    TRP_IDLE    = 3'd0,
    TRP_RATE    = 3'd1,
    TRP_POLAR   = 3'd2,
    TRP_CRCFAIL = 3'd3,
    TRP_CRCPASS = 3'd4
  } trpState_t;

  // strobes from control to datapath, all combinational in the current cycle
  typedef struct packed {
    logic acceptStart;
    logic gridWrite;
    logic takeIbar;
    logic takeResult;
  } seqStrobe_t;

endpackage

// File: rtl/ssbSeqCtrl.sv
module ssbSeqCtrl
  import ssbSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startIn,
  input  logic       sampleValid,
  input  logic       searchDone,
  input  logic       demodDone,
  input  logic       rateDone,
  input  logic       polarDone,
  input  logic       polarCrcOk,
  output seqStrobe_t strobe,
  output logic [1:0] phyStatus,
  output logic [2:0] trpStatus,
  output logic       searchStart,
  output logic       demodStart,
  output logic       rateStart,
  output logic       polarStart,
  output logic       resultValid,
  output logic       nextReady
);

  phyState_t phyQ, phyD;
  trpState_t trpQ, trpD;

  logic phyOpen;
  logic trpBusy;
  logic demodFin;
  logic rateFin;

  always_comb begin
    phyOpen           = (phyQ == PHY_IDLE) || (phyQ == PHY_GRID);
    trpBusy           = (trpQ == TRP_RATE) || (trpQ == TRP_POLAR);
    strobe.acceptStart = startIn && phyOpen && !trpBusy;
    strobe.gridWrite   = sampleValid && phyOpen;
    strobe.takeIbar    = searchDone && (phyQ == PHY_SEARCH);
    demodFin           = demodDone && (phyQ == PHY_DEMOD);
    rateFin            = rateDone && (trpQ == TRP_RATE);
    strobe.takeResult  = polarDone && (trpQ == TRP_POLAR);
  end

  // physical-channel progress
  always_comb begin
    phyD = phyQ;
    if (strobe.acceptStart)
      phyD = PHY_SEARCH;
    else if (strobe.gridWrite && phyQ == PHY_IDLE)
      phyD = PHY_GRID;
    else if (strobe.takeIbar)
      phyD = PHY_DEMOD;
    else if (demodFin)
      phyD = PHY_IDLE;
  end

  // transport-channel progress
  always_comb begin
    trpD = trpQ;
    if (strobe.acceptStart)
      trpD = TRP_IDLE;
    else if (demodFin)
      trpD = TRP_RATE;
    else if (rateFin)
      trpD = TRP_POLAR;
    else if (strobe.takeResult)
      trpD = polarCrcOk ? TRP_CRCPASS : TRP_CRCFAIL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phyQ        <= PHY_IDLE;
      trpQ        <= TRP_IDLE;
      searchStart <= 1'b0;
      demodStart  <= 1'b0;
      rateStart   <= 1'b0;
      polarStart  <= 1'b0;
      resultValid <= 1'b0;
      nextReady   <= 1'b0;
    end else begin
      phyQ        <= phyD;
      trpQ        <= trpD;
      searchStart <= strobe.acceptStart;
      demodStart  <= strobe.takeIbar;
      rateStart   <= demodFin;
      polarStart  <= rateFin;
      resultValid <= strobe.takeResult;
      nextReady   <= demodFin;
    end
  end

  assign phyStatus = phyQ;
  assign trpStatus = trpQ;

  // R3: search start coincides with entry to the search phase and a cleared verdict
  a_r3_search_entry: assert property (@(posedge clk) disable iff (rst)
    searchStart |-> (phyQ == PHY_SEARCH && trpQ == TRP_IDLE));

  // R4: a start during search or demodulation never launches a search
  a_r4_busy_start: assert property (@(posedge clk) disable iff (rst)
    (startIn && (phyQ == PHY_SEARCH || phyQ == PHY_DEMOD)) |=> !searchStart);

  // R6: the ready-for-next pulse rides with the hand-off into rate recovery
  a_r6_handoff: assert property (@(posedge clk) disable iff (rst)
    nextReady |-> (rateStart && phyQ == PHY_IDLE && trpQ == TRP_RATE));

  // R8: a result only appears alongside a verdict code
  a_r8_verdict: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (trpQ == TRP_CRCFAIL || trpQ == TRP_CRCPASS));

  // R10: a pass verdict holds while no start arrives
  a_r10_pass_hold: assert property (@(posedge clk) disable iff (rst)
    (trpQ == TRP_CRCPASS && !startIn) |=> (trpQ == TRP_CRCPASS));

  // R11: at most one stage is launched per cycle
  a_r11_one_stage: assert property (@(posedge clk) disable iff (rst)
    $onehot0({searchStart, demodStart, rateStart, polarStart}));

endmodule

// File: rtl/ssbSeqData.sv
module ssbSeqData
  import ssbSeqPkg::*;
#(
  parameter int CELL_W     = 10,
  parameter int BURST_W    = 2,
  parameter int IDX_W      = 3,
  parameter int PAY_W      = 32,
  parameter int GRID_DEPTH = 960,
  localparam int ADDR_W    = $clog2(GRID_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  input  logic [CELL_W-1:0]  cellIdIn,
  input  logic [BURST_W-1:0] burstCodeIn,
  input  logic [IDX_W-1:0]   searchIbar,
  input  logic [PAY_W-1:0]   polarPayload,
  output logic [CELL_W-1:0]  cfgCellId,
  output logic [BURST_W-1:0] cfgBurstCode,
  output logic [ADDR_W-1:0]  gridWrAddr,
  output logic [IDX_W-1:0]   blockIdx,
  output logic [PAY_W-1:0]   payload
);

  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(GRID_DEPTH - 1);

  logic [CELL_W-1:0]  cellQ;
  logic [BURST_W-1:0] burstQ;
  logic [IDX_W-1:0]   ibarQ;
  logic [IDX_W-1:0]   idxMap;
  logic [ADDR_W-1:0]  addrQ;
  logic               shortBurst;

  assign shortBurst = (burstQ == '0);

  // the top index bit is a half-frame bit when the burst holds four blocks
  for (genvar b = 0; b < IDX_W; b++) begin : g_idxBit
    if (b == IDX_W - 1) begin : g_top
      assign idxMap[b] = ibarQ[b] & ~shortBurst;
    end else begin : g_low
      assign idxMap[b] = ibarQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cellQ    <= '0;
      burstQ   <= '0;
      ibarQ    <= '0;
      addrQ    <= '0;
      blockIdx <= '0;
      payload  <= '0;
    end else begin
      if (strobe.acceptStart) begin
        cellQ  <= cellIdIn;
        burstQ <= burstCodeIn;
        addrQ  <= '0;
      end else if (strobe.gridWrite) begin
        addrQ <= (addrQ == ADDR_LAST) ? '0 : addrQ + 1'b1;
      end
      if (strobe.takeIbar)
        ibarQ <= searchIbar;
      if (strobe.takeResult) begin
        blockIdx <= idxMap;
        payload  <= polarPayload;
      end
    end
  end

  assign cfgCellId    = cellQ;
  assign cfgBurstCode = burstQ;
  assign gridWrAddr   = addrQ;

  // R2: a write below the last address steps the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (strobe.gridWrite && !strobe.acceptStart && addrQ != ADDR_LAST)
      |=> (addrQ == ADDR_W'($past(addrQ) + 1'b1)));

  // R2: a write at the last address wraps to zero
  a_r2_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe.gridWrite && !strobe.acceptStart && addrQ == ADDR_LAST) |=> (addrQ == '0));

  // R3: captured configuration only changes on an accepted start
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.acceptStart |=> ($stable(cellQ) && $stable(burstQ)));

  // R9: four-block bursts never report the top index bit
  a_r9_short_mask: assert property (@(posedge clk) disable iff (rst)
    (strobe.takeResult && shortBurst) |=> !blockIdx[IDX_W-1]);

endmodule

// File: rtl/ssbDecodeSeq.sv
module ssbDecodeSeq
  import ssbSeqPkg::*;
#(
  parameter int CELL_W     = 10,
  parameter int BURST_W    = 2,
  parameter int IDX_W      = 3,
  parameter int PAY_W      = 32,
  parameter int SAMPLE_W   = 16,
  parameter int GRID_DEPTH = 960,
  localparam int ADDR_W    = $clog2(GRID_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startIn,
  input  logic [CELL_W-1:0]   cellIdIn,
  input  logic [BURST_W-1:0]  burstCodeIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleRe,
  input  logic [SAMPLE_W-1:0] sampleIm,
  output logic                gridWrEn,
  output logic [ADDR_W-1:0]   gridWrAddr,
  output logic [SAMPLE_W-1:0] gridWrRe,
  output logic [SAMPLE_W-1:0] gridWrIm,
  output logic [CELL_W-1:0]   cfgCellId,
  output logic [BURST_W-1:0]  cfgBurstCode,
  output logic                searchStart,
  input  logic                searchDone,
  input  logic [IDX_W-1:0]    searchIbar,
  output logic                demodStart,
  input  logic                demodDone,
  output logic                rateStart,
  input  logic                rateDone,
  output logic                polarStart,
  input  logic                polarDone,
  input  logic                polarCrcOk,
  input  logic [PAY_W-1:0]    polarPayload,
  output logic [1:0]          phyStatus,
  output logic [2:0]          trpStatus,
  output logic [IDX_W-1:0]    blockIdx,
  output logic [PAY_W-1:0]    payload,
  output logic                resultValid,
  output logic                nextReady
);

  seqStrobe_t strobe;

  ssbSeqCtrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .startIn     (startIn),
    .sampleValid (sampleValid),
    .searchDone  (searchDone),
    .demodDone   (demodDone),
    .rateDone    (rateDone),
    .polarDone   (polarDone),
    .polarCrcOk  (polarCrcOk),
    .strobe      (strobe),
    .phyStatus   (phyStatus),
    .trpStatus   (trpStatus),
    .searchStart (searchStart),
    .demodStart  (demodStart),
    .rateStart   (rateStart),
    .polarStart  (polarStart),
    .resultValid (resultValid),
    .nextReady   (nextReady)
  );

  ssbSeqData #(
    .CELL_W     (CELL_W),
    .BURST_W    (BURST_W),
    .IDX_W      (IDX_W),
    .PAY_W      (PAY_W),
    .GRID_DEPTH (GRID_DEPTH)
  ) u_data (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .cellIdIn     (cellIdIn),
    .burstCodeIn  (burstCodeIn),
    .searchIbar   (searchIbar),
    .polarPayload (polarPayload),
    .cfgCellId    (cfgCellId),
    .cfgBurstCode (cfgBurstCode),
    .gridWrAddr   (gridWrAddr),
    .blockIdx     (blockIdx),
    .payload      (payload)
  );

  assign gridWrEn = strobe.gridWrite;
  assign gridWrRe = sampleRe;
  assign gridWrIm = sampleIm;

endmodule

// File: tb/sim_ssbDecodeSeq.sv
module sim_ssbDecodeSeq;

  localparam int GRID = 960;

  logic        clk = 1'b0;
  logic        rst;
  logic        startIn, sampleValid;
  logic [9:0]  cellIdIn;
  logic [1:0]  burstCodeIn;
  logic [15:0] sampleRe, sampleIm;
  logic        searchDone, demodDone, rateDone, polarDone, polarCrcOk;
  logic [2:0]  searchIbar;
  logic [31:0] polarPayload;

  logic        gridWrEn;
  logic [9:0]  gridWrAddr;
  logic [15:0] gridWrRe, gridWrIm;
  logic [9:0]  cfgCellId;
  logic [1:0]  cfgBurstCode;
  logic        searchStart, demodStart, rateStart, polarStart, resultValid, nextReady;
  logic [1:0]  phyStatus;
  logic [2:0]  trpStatus;
  logic [2:0]  blockIdx;
  logic [31:0] payload;

  always #5 clk = ~clk;

  ssbDecodeSeq u0 (
    .clk(clk), .rst(rst), .startIn(startIn), .cellIdIn(cellIdIn),
    .burstCodeIn(burstCodeIn), .sampleValid(sampleValid),
    .sampleRe(sampleRe), .sampleIm(sampleIm),
    .gridWrEn(gridWrEn), .gridWrAddr(gridWrAddr),
    .gridWrRe(gridWrRe), .gridWrIm(gridWrIm),
    .cfgCellId(cfgCellId), .cfgBurstCode(cfgBurstCode),
    .searchStart(searchStart), .searchDone(searchDone), .searchIbar(searchIbar),
    .demodStart(demodStart), .demodDone(demodDone),
    .rateStart(rateStart), .rateDone(rateDone),
    .polarStart(polarStart), .polarDone(polarDone),
    .polarCrcOk(polarCrcOk), .polarPayload(polarPayload),
    .phyStatus(phyStatus), .trpStatus(trpStatus),
    .blockIdx(blockIdx), .payload(payload),
    .resultValid(resultValid), .nextReady(nextReady)
  );

  // reference model state
  int          mPhy, mTrp, mAddr, mIbar, mIdx;
  logic [9:0]  mCell;
  logic [1:0]  mBurst;
  logic [31:0] mPay;
  bit          mSS, mDS, mRS, mPS, mRV, mNx;
  bit          started = 0;
  int          nChecks = 0, nFails = 0;
  string       curReq = "R1";

  always @(posedge clk) begin
    bit acc, wr, tI, dF, rF, tR;
    started = 1;
    if (rst) begin
      mPhy = 0; mTrp = 0; mAddr = 0; mIbar = 0; mIdx = 0;
      mCell = '0; mBurst = '0; mPay = '0;
      mSS = 0; mDS = 0; mRS = 0; mPS = 0; mRV = 0; mNx = 0;
    end else begin
      acc = startIn && mPhy <= 1 && mTrp != 1 && mTrp != 2;
      wr  = sampleValid && mPhy <= 1;
      tI  = searchDone && mPhy == 2;
      dF  = demodDone && mPhy == 3;
      rF  = rateDone && mTrp == 1;
      tR  = polarDone && mTrp == 2;
      mSS = acc; mDS = tI; mRS = dF; mNx = dF; mPS = rF; mRV = tR;
      if (tR) begin
        mIdx = (mBurst == 2'd0) ? (mIbar & 3) : mIbar;
        mPay = polarPayload;
      end
      if (acc) begin
        mCell = cellIdIn; mBurst = burstCodeIn; mAddr = 0;
      end else if (wr) begin
        mAddr = (mAddr == GRID - 1) ? 0 : mAddr + 1;
      end
      if (tI) mIbar = searchIbar;
      if (acc) mPhy = 2;
      else if (wr && mPhy == 0) mPhy = 1;
      else if (tI) mPhy = 3;
      else if (dF) mPhy = 0;
      if (acc) mTrp = 0;
      else if (dF) mTrp = 1;
      else if (rF) mTrp = 2;
      else if (tR) mTrp = polarCrcOk ? 4 : 3;
    end
  end

  task automatic chk(string sig, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("phyStatus", 32'(phyStatus), 32'(mPhy));
      chk("trpStatus", 32'(trpStatus), 32'(mTrp));
      chk("gridWrEn", 32'(gridWrEn), 32'(sampleValid && mPhy <= 1 && !rst));
      chk("gridWrAddr", 32'(gridWrAddr), 32'(mAddr));
      chk("gridWrRe", 32'(gridWrRe), 32'(sampleRe));
      chk("cfgCellId", 32'(cfgCellId), 32'(mCell));
      chk("cfgBurstCode", 32'(cfgBurstCode), 32'(mBurst));
      chk("searchStart", 32'(searchStart), 32'(mSS));
      chk("demodStart", 32'(demodStart), 32'(mDS));
      chk("rateStart", 32'(rateStart), 32'(mRS));
      chk("polarStart", 32'(polarStart), 32'(mPS));
      chk("resultValid", 32'(resultValid), 32'(mRV));
      chk("nextReady", 32'(nextReady), 32'(mNx));
      chk("blockIdx", 32'(blockIdx), 32'(mIdx));
      chk("payload", payload, mPay);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog %s: actual hung expected done", curReq);
    finishRun();
  end

  initial begin
    rst = 1; startIn = 0; sampleValid = 0; cellIdIn = '0; burstCodeIn = '0;
    sampleRe = 16'h0101; sampleIm = 16'h0202;
    searchDone = 0; demodDone = 0; rateDone = 0; polarDone = 0; polarCrcOk = 0;
    searchIbar = '0; polarPayload = '0;
    step(3);
    rst = 0;
    curReq = "R1"; step(2);

    curReq = "R2"; sampleValid = 1;
    for (int i = 0; i < 5; i++) begin sampleRe = 16'(i * 7); step(); end
    sampleValid = 0; step();

    curReq = "R3"; startIn = 1; cellIdIn = 10'h155; burstCodeIn = 2'd0; step();
    startIn = 0; cellIdIn = '0; step(2);

    curReq = "R11"; sampleValid = 1; step(3); sampleValid = 0;
    curReq = "R4"; startIn = 1; cellIdIn = 10'h0AA; burstCodeIn = 2'd1; step();
    startIn = 0; step();
    curReq = "R11"; demodDone = 1; rateDone = 1; polarDone = 1; step();
    demodDone = 0; rateDone = 0; polarDone = 0; step();

    curReq = "R5"; searchIbar = 3'd7; searchDone = 1; step();
    searchDone = 0; searchIbar = '0; step(2);
    curReq = "R4"; startIn = 1; step(); startIn = 0; step();
    curReq = "R11"; searchDone = 1; searchIbar = 3'd1; step(); searchDone = 0; step();

    curReq = "R6"; demodDone = 1; step(); demodDone = 0; step(2);
    curReq = "R7"; rateDone = 1; step(); rateDone = 0; step(2);
    curReq = "R8"; polarPayload = 32'h0D00_00A0; polarCrcOk = 1; polarDone = 1; step();
    polarDone = 0; polarCrcOk = 0; polarPayload = '0; step();
    curReq = "R9"; step(2);
    curReq = "R10"; polarDone = 1; rateDone = 1; step(); polarDone = 0; rateDone = 0;
    sampleValid = 1; step(3); sampleValid = 0; step(2);

    curReq = "R9"; startIn = 1; cellIdIn = 10'h3FF; burstCodeIn = 2'd1; step();
    startIn = 0; step();
    searchIbar = 3'd5; searchDone = 1; step(); searchDone = 0; step();
    demodDone = 1; step(); demodDone = 0;
    curReq = "R2"; sampleValid = 1; step(3); sampleValid = 0;
    curReq = "R7"; rateDone = 1; step(); rateDone = 0;
    curReq = "R4"; startIn = 1; cellIdIn = 10'h011; step(); startIn = 0; step();
    curReq = "R8"; polarPayload = 32'h1234_5678; polarCrcOk = 0; polarDone = 1; step();
    polarDone = 0; polarPayload = '0; step();
    curReq = "R10"; sampleValid = 1; step(4); sampleValid = 0; step();

    curReq = "R3"; startIn = 1; cellIdIn = 10'h001; burstCodeIn = 2'd2; step();
    startIn = 0; step(2);
    curReq = "R1"; searchDone = 1; searchIbar = 3'd6; step(); searchDone = 0;
    rst = 1; step(); rst = 0; step(2);

    curReq = "R2"; sampleValid = 1;
    for (int i = 0; i < GRID + 5; i++) begin sampleIm = 16'(i); step(); end
    sampleValid = 0; step(2);

    finishRun();
  end

endmodule